// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Register Bank

The block drives four independent pulse-width modulated outputs, all configured through one small memory-mapped port. Each channel has four parts: a power-of-two clock divider, a 16-bit count that runs through one period, a compare against a duty value that sets the inactive tail of each period, and a polarity select. Software starts channels through one write-one register and stops them through another. It reads a status word that shows which channels are running, and an event word that records finished periods and empties itself when read.

Duty and period values can be changed in two ways. A write to the direct registers takes effect at once. A write to the staged registers is held until the running period finishes, so the waveform never shows a period that is half old and half new. The event word is how software learns that a staged value has been loaded. A stop request also waits for the period in progress to finish before the channel goes idle.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads 0, no channel runs, and each output sits at its inactive level, which is low when the polarity bit is 0.
- R2: A write to 0x004 starts channel n for each set bit n and leaves channels whose bit is 0 untouched. Status at 0x00C shows bit n high while channel n runs.
- R3: A running channel with period P and duty D counts P prescaled clocks per period from 0. It is active while the count is below P-D. The pin is the active flag XOR the polarity bit, and the count starts at 0 on the cycle after the start write.
- R4: Mode bits [3:0] select exponent E, and the count advances once every 2^E input clocks. Values of E above 10 behave as 10 but read back as written.
- R5: Values written to the staged duty (offset 0x08) and staged period (offset 0x10) registers read back at once. They are copied into the active duty and period registers only at the next period end.
- R6: Writes to the mode register (offset 0x00), the duty register (offset 0x04) and the period register (offset 0x0C) change the waveform from the next clock, even while the channel runs.
- R7: A write to 0x008 asks channel n to stop for each set bit n. Status stays high until the period in progress ends, and then the pin goes inactive. A later start begins again with count 0 and a fresh divider.
- R8: Event bit n at 0x01C is set when channel n ends a period. A read returns the word and clears all of it, but a period end in the same cycle as the read still sets its bit.
- R9: A duty value above the period keeps the pin inactive for the whole period, and a period of 0 keeps it inactive all the time.
- R10: Channel n's registers lie at 0x200 + 0x20*n. The mode register shows the exponent in bits [3:0] and polarity in bit 9. Unmapped addresses read 0, and read data appears on the clock after the cycle in which read enable is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| rdata | output | 16 | Registered read data |
| pwm_out | output | 4 | Modulated outputs, one per channel |

## Verification
Register writes change state at the clock edge that samples them. Read data appears after the edge that samples the read, so a read issued in cycle c is due after edge c+1. After the edge that samples a start write, the pin shows count 0. After that it shows count floor(j/2^E) mod P, j edges later. The bench stamps every expected item with the edge after which it falls due, and a monitor checks it a few nanoseconds after that edge. Events, staged loads and stop completion are placed on the period-end edges computed from this count, so every check lands on the exact cycle the requirements give.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and register offsets of the PWM bank.
// Assumes byte addressing and one register per 4-byte word.
package pwm_pkg;
    localparam int unsigned N_CH    = 4;
    localparam int unsigned CNT_W   = 16;
    localparam int unsigned EXP_W   = 4;
    localparam int unsigned EXP_MAX = 10;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned POL_BIT = 9;

    // global word offsets
    localparam logic [ADDR_W-1:0] OFS_START  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_STOP   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 12'h01C;

    // channel windows
    localparam int unsigned CH_BASE   = 'h200;
    localparam int unsigned CH_STRIDE = 'h20;
    localparam int unsigned SUB_W     = $clog2(CH_STRIDE);

    // offsets inside one channel window
    localparam logic [SUB_W-1:0] SUB_MODE   = 5'h00;
    localparam logic [SUB_W-1:0] SUB_DUTY   = 5'h04;
    localparam logic [SUB_W-1:0] SUB_DUTY_S = 5'h08;
    localparam logic [SUB_W-1:0] SUB_PER    = 5'h0C;
    localparam logic [SUB_W-1:0] SUB_PER_S  = 5'h10;
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
// Module: pwm_prescaler
// Emits a one-cycle tick every 2^E clocks while run is high, with E the
// exponent clamped to EXP_MAX. Assumes the divider restarts whenever run is low.
module pwm_prescaler #(
    parameter int unsigned EXP_W   = 4,
    parameter int unsigned EXP_MAX = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);
    localparam int unsigned PW = (EXP_MAX > 0) ? EXP_MAX : 1;

    logic [PW-1:0]    pre_q;
    logic [PW-1:0]    mask;
    logic [EXP_W-1:0] exp_eff;

    // clamp the exponent to the largest supported division
    always_comb exp_eff = (exp_sel > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_sel;

    // build a mask of the low exp_eff bits
    always_comb begin
        mask = '0;
        for (int i = 0; i < int'(PW); i++) mask[i] = (i < int'(exp_eff));
    end

    // free divider that restarts while the channel is idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else                pre_q <= pre_q + PW'(1);
    end

    assign tick = run && ((pre_q & mask) == mask);

    // with a nonzero exponent two ticks never come back to back (R4)
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(tick) && exp_sel != '0 && $stable(exp_sel)) |-> !tick);
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
// Module: pwm_channel
// One PWM channel: mode, direct and staged duty/period registers, the period
// count and the pin. Assumes at most one write strobe per cycle from the decoder.
module pwm_channel #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned EXP_W   = 4,
    parameter int unsigned EXP_MAX = 10,
    parameter int unsigned POL_BIT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             wr_mode,
    input  logic             wr_duty,
    input  logic             wr_duty_s,
    input  logic             wr_per,
    input  logic             wr_per_s,
    input  logic             start,
    input  logic             stop,
    output logic             running,
    output logic             per_end,
    output logic             pin,
    output logic [CNT_W-1:0] rb_mode,
    output logic [CNT_W-1:0] rb_duty,
    output logic [CNT_W-1:0] rb_duty_s,
    output logic [CNT_W-1:0] rb_per,
    output logic [CNT_W-1:0] rb_per_s
);
    logic [EXP_W-1:0] exp_q;
    logic             pol_q;
    logic [CNT_W-1:0] duty_q, per_q, duty_s_q, per_s_q, cnt_q, hi_len;
    logic             duty_pend, per_pend, run_q, stop_q, tick, active;

    pwm_prescaler #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .exp_sel(exp_q), .tick(tick)
    );

    // last prescaled clock of the period (every tick when the period is 0)
    assign per_end = run_q && tick &&
                     (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, per_q});

    // mode register: exponent and polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            pol_q <= 1'b0;
        end else if (wr_mode) begin
            exp_q <= wr_val[EXP_W-1:0];
            pol_q <= wr_val[POL_BIT];
        end
    end

    // active duty/period: staged load at period end beats a direct write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            per_q  <= '0;
        end else begin
            if (per_end && duty_pend) duty_q <= duty_s_q;
            else if (wr_duty)         duty_q <= wr_val;
            if (per_end && per_pend)  per_q  <= per_s_q;
            else if (wr_per)          per_q  <= wr_val;
        end
    end

    // staged values and their pending flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_s_q  <= '0;
            per_s_q   <= '0;
            duty_pend <= 1'b0;
            per_pend  <= 1'b0;
        end else begin
            if (wr_duty_s) begin
                duty_s_q  <= wr_val;
                duty_pend <= 1'b1;
            end else if (per_end) duty_pend <= 1'b0;
            if (wr_per_s) begin
                per_s_q  <= wr_val;
                per_pend <= 1'b1;
            end else if (per_end) per_pend <= 1'b0;
        end
    end

    // run state: start wins, stop waits for the period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            stop_q <= 1'b0;
        end else if (start) begin
            run_q  <= 1'b1;
            stop_q <= 1'b0;
        end else if (per_end && stop_q) begin
            run_q  <= 1'b0;
            stop_q <= 1'b0;
        end else if (stop && run_q) begin
            stop_q <= 1'b1;
        end
    end

    // period count
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q) cnt_q <= '0;
        else if (per_end)     cnt_q <= '0;
        else if (tick)        cnt_q <= cnt_q + CNT_W'(1);
    end

    // waveform: active for the first per-duty counts of each period
    always_comb begin
        hi_len = per_q - duty_q;
        active = run_q && (duty_q <= per_q) && (cnt_q < hi_len);
    end

    assign pin     = active ^ pol_q;
    assign running = run_q;

    // readback views
    always_comb begin
        rb_mode                = '0;
        rb_mode[EXP_W-1:0]     = exp_q;
        rb_mode[POL_BIT]       = pol_q;
    end
    assign rb_duty   = duty_q;
    assign rb_duty_s = duty_s_q;
    assign rb_per    = per_q;
    assign rb_per_s  = per_s_q;

    p_stop_on_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(per_end));
    p_stage_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (per_end && duty_pend) |=> (duty_q == $past(duty_s_q)));
    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (pin == pol_q));
    p_wide_duty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q > per_q) |-> (pin == pol_q));
    p_count_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (cnt_q == '0));
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
// Module: pwm_bank
// Register decoder, event word and read mux around N channel instances.
// Assumes single-cycle accesses and that read data is taken one clock later.
module pwm_bank #(
    parameter int unsigned NUM_CH = pwm_pkg::N_CH,
    parameter int unsigned DATA_W = pwm_pkg::CNT_W,
    parameter int unsigned ADDR_W = pwm_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    import pwm_pkg::*;
    localparam int unsigned BLK_W = ADDR_W - SUB_W;

    logic [NUM_CH-1:0] run_v, end_v, hit_v, evt_q;
    logic [DATA_W-1:0] mode_rb [NUM_CH];
    logic [DATA_W-1:0] duty_rb [NUM_CH];
    logic [DATA_W-1:0] dutys_rb[NUM_CH];
    logic [DATA_W-1:0] per_rb  [NUM_CH];
    logic [DATA_W-1:0] pers_rb [NUM_CH];
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic [SUB_W-1:0]  sub;
    logic              wr_start, wr_stop, rd_evt;

    assign sub      = addr[SUB_W-1:0];
    assign wr_start = wr_en && (addr == OFS_START);
    assign wr_stop  = wr_en && (addr == OFS_STOP);
    assign rd_evt   = rd_en && (addr == OFS_EVENT);

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
        localparam int unsigned BLK_I = CH_BASE / CH_STRIDE + g;
        assign hit_v[g] = (addr[ADDR_W-1:SUB_W] == BLK_W'(BLK_I));

        pwm_channel #(
            .CNT_W(DATA_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .POL_BIT(POL_BIT)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .wr_val(wdata),
            .wr_mode  (wr_en && hit_v[g] && sub == SUB_MODE),
            .wr_duty  (wr_en && hit_v[g] && sub == SUB_DUTY),
            .wr_duty_s(wr_en && hit_v[g] && sub == SUB_DUTY_S),
            .wr_per   (wr_en && hit_v[g] && sub == SUB_PER),
            .wr_per_s (wr_en && hit_v[g] && sub == SUB_PER_S),
            .start(wr_start && wdata[g]), .stop(wr_stop && wdata[g]),
            .running(run_v[g]), .per_end(end_v[g]), .pin(pwm_out[g]),
            .rb_mode(mode_rb[g]), .rb_duty(duty_rb[g]), .rb_duty_s(dutys_rb[g]),
            .rb_per(per_rb[g]), .rb_per_s(pers_rb[g])
        );
    end

    // event word: read clears, a period end in the same cycle still sets
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (rd_evt ? '0 : evt_q) | end_v;
    end

    // read selection over global and channel registers
    always_comb begin
        rd_mux = '0;
        if (addr == OFS_STATUS)     rd_mux[NUM_CH-1:0] = run_v;
        else if (addr == OFS_EVENT) rd_mux[NUM_CH-1:0] = evt_q;
        for (int n = 0; n < int'(NUM_CH); n++) begin
            if (hit_v[n]) begin
                case (sub)
                    SUB_MODE:   rd_mux = mode_rb[n];
                    SUB_DUTY:   rd_mux = duty_rb[n];
                    SUB_DUTY_S: rd_mux = dutys_rb[n];
                    SUB_PER:    rd_mux = per_rb[n];
                    SUB_PER_S:  rd_mux = pers_rb[n];
                    default:    rd_mux = '0;
                endcase
            end
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end
    assign rdata = rdata_q;

    p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> ((run_v & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0])));
    p_event_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|end_v) |=> ((evt_q & $past(end_v)) == $past(end_v)));
    p_event_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && end_v == '0) |=> (evt_q == '0));
endmodule

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks push expected items stamped with their due edge,
// a monitor compares them a few ns after that edge.
module tb_pwm_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] rdata;
    logic [3:0]  pwm_out;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          kind;   // 0: rdata, 1: pwm_out
        logic [15:0] mask;
        logic [15:0] expv;
        string       tag;
    } item_t;
    item_t sb[$];

    pwm_bank dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                  .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pwm_out(pwm_out));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] lvl(int j, int e, int p, int d, logic pol, int b);
        int  c;
        logic act;
        c   = (p > 0) ? ((j >> e) % p) : 0;
        act = (p > 0) && (d <= p) && (c < p - d);
        return 16'(act ^ pol) << b;
    endfunction

    task automatic push(int due, int kind, logic [15:0] m, logic [15:0] v, string tag);
        item_t it;
        it.due = due; it.kind = kind; it.mask = m; it.expv = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic sync_to(int c);
        do @(negedge clk); while (cyc < c);
    endtask

    task automatic release_bus();
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(int c, logic [11:0] a, logic [15:0] d);
        sync_to(c);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        release_bus();
    endtask

    task automatic rd(int c, logic [11:0] a, logic [15:0] m, logic [15:0] v, string tag);
        sync_to(c);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        push(cyc + 1, 0, m, v, tag);
        release_bus();
    endtask

    // monitor: compare every item that falls due on this edge
    initial begin
        forever begin
            @(posedge clk); #3;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due <= cyc) begin
                    logic [15:0] act;
                    act = (sb[i].kind == 0) ? rdata : {12'b0, pwm_out};
                    n_chk++;
                    if (sb[i].due < cyc || ((act & sb[i].mask) !== (sb[i].expv & sb[i].mask))) begin
                        n_fail++;
                        $display("FAIL %s cycle %0d: actual=%h expected=%h mask=%h",
                                 sb[i].tag, sb[i].due, act, sb[i].expv, sb[i].mask);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int t0, t2, t3;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        push(cyc + 1, 1, 16'hF, 16'h0, "R1");
        rd(0, 12'h00C, 16'hFFFF, 16'h0, "R1");
        rd(0, 12'h01C, 16'hFFFF, 16'h0, "R1");
        rd(0, 12'h200, 16'hFFFF, 16'h0, "R1");
        rd(0, 12'h20C, 16'hFFFF, 16'h0, "R1");
        rd(0, 12'h210, 16'hFFFF, 16'h0, "R1");

        // phase A: channel 0, E=0, P=10, D=4; channel 1 idle with polarity 1
        wr(0, 12'h20C, 16'd10);
        wr(0, 12'h204, 16'd4);
        wr(0, 12'h220, 16'h0201);
        wr(0, 12'h22C, 16'd6);
        push(cyc + 1, 1, 16'h2, 16'h2, "R1");
        rd(0, 12'h20C, 16'hFFFF, 16'd10, "R10");
        rd(0, 12'h220, 16'hFFFF, 16'h0201, "R10");
        rd(0, 12'h100, 16'hFFFF, 16'h0, "R10");
        wr(0, 12'h004, 16'h0001);
        t0 = cyc;
        for (int j = 0; j < 30; j++)
            push(t0 + j, 1, 16'h1, lvl(j, 0, 10, (j < 20) ? 4 : 7, 1'b0, 0), (j < 20) ? "R3" : "R5");
        for (int j = 30; j < 40; j++) push(t0 + j, 1, 16'h1, 16'h1, "R6");
        for (int j = 40; j < 55; j++) push(t0 + j, 1, 16'h1, 16'h0, "R9");
        rd(t0, 12'h00C, 16'hFFFF, 16'h1, "R2");
        rd(t0 + 4, 12'h01C, 16'hFFFF, 16'h0, "R8");
        rd(t0 + 12, 12'h01C, 16'hFFFF, 16'h1, "R8");
        rd(t0 + 14, 12'h01C, 16'hFFFF, 16'h0, "R8");
        wr(t0 + 15, 12'h208, 16'd7);
        rd(t0 + 16, 12'h204, 16'hFFFF, 16'd4, "R5");
        rd(t0 + 17, 12'h208, 16'hFFFF, 16'd7, "R5");
        rd(t0 + 19, 12'h01C, 16'hFFFF, 16'h0, "R8");
        rd(t0 + 20, 12'h01C, 16'hFFFF, 16'h1, "R8");
        rd(t0 + 21, 12'h204, 16'hFFFF, 16'd7, "R5");
        wr(t0 + 29, 12'h204, 16'd0);
        wr(t0 + 39, 12'h204, 16'd12);
        wr(t0 + 49, 12'h20C, 16'd0);
        rd(t0 + 51, 12'h20C, 16'hFFFF, 16'd0, "R6");
        wr(t0 + 55, 12'h008, 16'h0001);
        rd(t0 + 58, 12'h00C, 16'hFFFF, 16'h0, "R7");

        // phase B: channel 2, E=2, P=3, D=1, stop mid-run, restart
        wr(0, 12'h240, 16'h0002);
        wr(0, 12'h24C, 16'd3);
        wr(0, 12'h244, 16'd1);
        wr(0, 12'h004, 16'h0004);
        t2 = cyc;
        for (int j = 0; j < 24; j++) push(t2 + j, 1, 16'h4, lvl(j, 2, 3, 1, 1'b0, 2), "R4");
        for (int j = 24; j < 29; j++) push(t2 + j, 1, 16'h4, 16'h0, "R7");
        wr(t2 + 13, 12'h008, 16'h0004);
        rd(t2 + 14, 12'h00C, 16'h4, 16'h4, "R7");
        rd(t2 + 25, 12'h00C, 16'h4, 16'h0, "R7");
        rd(t2 + 26, 12'h01C, 16'h4, 16'h4, "R8");
        wr(t2 + 30, 12'h004, 16'h0004);
        t2 = cyc;
        for (int j = 0; j < 12; j++) push(t2 + j, 1, 16'h4, lvl(j, 2, 3, 1, 1'b0, 2), "R7");

        // phase C: channel 3, exponent 15 behaves as 10
        wr(0, 12'h260, 16'h000F);
        wr(0, 12'h26C, 16'd2);
        wr(0, 12'h264, 16'd1);
        rd(0, 12'h260, 16'hFFFF, 16'h000F, "R4");
        wr(0, 12'h004, 16'h0008);
        t3 = cyc;
        push(t3,        1, 16'h8, 16'h8, "R4");
        push(t3 + 1023, 1, 16'h8, 16'h8, "R4");
        push(t3 + 1024, 1, 16'h8, 16'h0, "R4");
        push(t3 + 2047, 1, 16'h8, 16'h0, "R4");
        push(t3 + 2048, 1, 16'h8, 16'h8, "R4");
        sync_to(t3 + 2050);
        while (sb.size() != 0) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule